// File: doc/BRIEF.md
# I2C Master Receiver Status Engine

This block is a byte-level I2C master that reads from slave devices. It drives the clock and data lines through open-drain pull-down enables, runs the bus clock from a programmable divider and, after each bus event, halts with SCL held low. It then posts an 8-bit status code and raises an event flag. Software reads the code, may load the data register with an address byte, and resumes the engine by writing a command that has the flag-clear bit set. That same command carries start, stop and acknowledge-enable bits, and the engine's next move depends on those bits together with the code it is currently showing.

The engine can issue START, repeated START, an address byte taken from the data register, data reception ending in an ACK or NACK of the caller's choice, STOP, and STOP followed by a fresh START. It detects loss of arbitration to another master. A write address (LSB 0) is sent and its acknowledge is reported, which hands the transfer over to transmitter-side handling outside this block. Each bit takes four divider ticks: SDA is set, SCL is released, SDA is sampled, and SCL is pulled low again. SDA changes while SCL is high only to form a START or a STOP.

Top module: `i2c_master_rx_engine`

## Requirements
- R1: After reset the status reads 0xF8, the event flag is low and neither SCL nor SDA is pulled low.
- R2: A command with the start bit set while idle waits for a free bus (both lines high) and then sends a START. The engine posts 0x08 and keeps SCL low for as long as the flag stays set.
- R3: Clearing the flag from 0x08 or 0x10 sends the data register MSB first. A read address (bit 0 = 1) posts 0x40 if the slave acknowledges and 0x48 if it does not.
- R4: Clearing the flag from 0x40 or 0x50 receives one byte into the data register. With acknowledge-enable 1 the engine drives ACK (SDA low) and posts 0x50. With acknowledge-enable 0 it leaves SDA released in the acknowledge slot and posts 0x58.
- R5: Clearing the flag from 0x48, 0x58, 0x18 or 0x20 with start=1 and stop=0 sends a repeated START and posts 0x10. A new address, to the same slave or another one, can follow without a STOP.
- R6: Clearing the flag from those same codes with stop=1 and start=0 sends a STOP. The engine then returns to idle with status 0xF8, both lines released, and the stop-pending bit cleared by itself.
- R7: Clearing the flag with stop=1 and start=1 sends a STOP, then a START once the bus is free, and posts 0x08.
- R8: When the engine has released SDA but samples it low while SCL is high, during an address bit or a NACK slot, it releases both lines and posts 0x38.
- R9: Clearing the flag from 0x38 with start=0 leaves the bus released and the status at 0xF8. With start=1 the engine drives nothing while the bus stays busy, and it sends a START (0x08) once the bus is free.
- R10: A write address (bit 0 = 0) posts 0x18 if the slave acknowledges and 0x20 if it does not.
- R11: The low three bits of the status are always zero. A command without the clear bit leaves the flag and the status unchanged, and a command with the clear bit drops the flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| ctrlWr | input | 1 | Command write strobe |
| ctrlStart | input | 1 | Start request bit of the command |
| ctrlStop | input | 1 | Stop request bit of the command |
| ctrlAck | input | 1 | Acknowledge-enable bit of the command |
| ctrlClear | input | 1 | Write-one-to-clear bit for the event flag |
| dataWr | input | 1 | Data register write strobe |
| dataIn | input | 8 | Data register write value |
| dataOut | output | 8 | Data register: last received byte or loaded address |
| status | output | 8 | Status code of the last bus event |
| eventFlag | output | 1 | Set when a bus event has completed |
| stopPending | output | 1 | Stop request bit, cleared by the engine after the STOP |

## Verification
The bench goes after the acknowledge slot, where an engine that inverts its ACK/NACK choice would make the slave keep sending, or stop sending, at the wrong time. It also checks that a NACK slot pulled low by another master is reported as lost arbitration and not as a clean 0x58. Repeated START is checked toward a second, absent slave, and STOP followed by START is checked as well. An engine that forgets the stop bit, skips the STOP or never restarts shows a wrong code or a missing stop count. After 0x38 the bench holds the bus busy: a design that ignores bus-free detection would drive the lines or post 0x08 too early.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

  localparam int DATA_W = 8;

  localparam logic [7:0] CODE_START      = 8'h08;
  localparam logic [7:0] CODE_RSTART     = 8'h10;
  localparam logic [7:0] CODE_WADDR_ACK  = 8'h18;
  localparam logic [7:0] CODE_WADDR_NACK = 8'h20;
  localparam logic [7:0] CODE_LOST       = 8'h38;
  localparam logic [7:0] CODE_RADDR_ACK  = 8'h40;
  localparam logic [7:0] CODE_RADDR_NACK = 8'h48;
  localparam logic [7:0] CODE_RX_ACK     = 8'h50;
  localparam logic [7:0] CODE_RX_NACK    = 8'h58;
  localparam logic [7:0] CODE_NONE       = 8'hF8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAITFREE, ST_START, ST_RSTART, ST_ADDR,
    ST_ADDRACK, ST_RXBIT, ST_RXACK, ST_STOP, ST_HOLD
  } ctrlState_e;

  typedef struct packed {
    logic phaseClr;
    logic loadAddr;
    logic bitClr;
    logic shiftTx;
    logic shiftRx;
    logic commitRx;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_mrx_datapath.sv
module i2c_mrx_datapath
  import i2c_mrx_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sampleBit,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              tick,
  output logic [1:0]        phase,
  output logic              lastBit,
  output logic              txBit,
  output logic              rwBit,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_TOP = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataReg;
  logic              rwReg;

  assign tick    = (divCnt == DIV_TOP);
  assign lastBit = (bitCnt == BIT_TOP);
  assign txBit   = shiftReg[DATA_W-1];
  assign rwBit   = rwReg;
  assign dataOut = dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 2'd0;
    end else if (strobe.phaseClr) begin
      divCnt <= '0;
      phase  <= 2'd0;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      rwReg    <= 1'b0;
    end else begin
      if (strobe.bitClr)
        bitCnt <= '0;
      else if (strobe.shiftTx || strobe.shiftRx)
        bitCnt <= bitCnt + 1'b1;
      if (strobe.loadAddr) begin
        shiftReg <= dataReg;
        rwReg    <= dataReg[0];
      end else if (strobe.shiftTx)
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      else if (strobe.shiftRx)
        shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dataReg <= '0;
    else if (dataWr)
      dataReg <= dataIn;
    else if (strobe.commitRx)
      dataReg <= shiftReg;
  end

endmodule

// File: rtl/i2c_mrx_control.sv
module i2c_mrx_control
  import i2c_mrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] phase,
  input  logic       lastBit,
  input  logic       txBit,
  input  logic       rwBit,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       ctrlWr,
  input  logic       ctrlStart,
  input  logic       ctrlStop,
  input  logic       ctrlAck,
  input  logic       ctrlClear,
  output dpStrobe_t  strobe,
  output logic       sampleBit,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [7:0] status,
  output logic       eventFlag,
  output logic       stopPending
);

  ctrlState_e state;
  logic startReq, ackEn, sclLow, sdaLow, busFree, accept, idleGo;

  assign busFree     = sclIn && sdaIn;
  assign accept      = ctrlWr && ctrlClear && (state == ST_HOLD);
  assign idleGo      = ctrlWr && ctrlStart && (state == ST_IDLE);
  assign sclOe       = sclLow;
  assign sdaOe       = sdaLow;

  always_comb begin
    strobe          = '0;
    strobe.phaseClr = accept || (state == ST_WAITFREE && tick && busFree);
    strobe.loadAddr = accept && (status == CODE_START || status == CODE_RSTART);
    strobe.bitClr   = strobe.loadAddr ||
                      (accept && (status == CODE_RADDR_ACK || status == CODE_RX_ACK));
    strobe.shiftTx  = (state == ST_ADDR)  && tick && (phase == 2'd3);
    strobe.shiftRx  = (state == ST_RXBIT) && tick && (phase == 2'd3);
    strobe.commitRx = (state == ST_RXACK) && tick && (phase == 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      status      <= CODE_NONE;
      eventFlag   <= 1'b0;
      startReq    <= 1'b0;
      stopPending <= 1'b0;
      ackEn       <= 1'b0;
      sclLow      <= 1'b0;
      sdaLow      <= 1'b0;
      sampleBit   <= 1'b1;
    end else begin
      if (ctrlWr) begin
        startReq    <= ctrlStart;
        stopPending <= ctrlStop;
        ackEn       <= ctrlAck;
      end
      unique case (state)
        ST_IDLE: if (idleGo) state <= ST_WAITFREE;
        ST_WAITFREE: if (tick && busFree) state <= ST_START;
        ST_START: if (tick) begin
          if (phase == 2'd0) sdaLow <= 1'b1;
          if (phase == 2'd3) begin
            sclLow <= 1'b1; status <= CODE_START; eventFlag <= 1'b1; state <= ST_HOLD;
          end
        end
        ST_RSTART: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= 1'b0;
            2'd1: sclLow <= 1'b0;
            2'd2: sdaLow <= 1'b1;
            default: begin
              sclLow <= 1'b1; status <= CODE_RSTART; eventFlag <= 1'b1; state <= ST_HOLD;
            end
          endcase
        end
        ST_ADDR: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= ~txBit;
            2'd1: sclLow <= 1'b0;
            2'd2: begin
              sampleBit <= sdaIn;
              if (txBit && !sdaIn) begin
                sclLow <= 1'b0; sdaLow <= 1'b0; status <= CODE_LOST;
                eventFlag <= 1'b1; state <= ST_HOLD;
              end
            end
            default: begin
              sclLow <= 1'b1;
              if (lastBit) state <= ST_ADDRACK;
            end
          endcase
        end
        ST_ADDRACK: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= 1'b0;
            2'd1: sclLow <= 1'b0;
            2'd2: sampleBit <= sdaIn;
            default: begin
              sclLow <= 1'b1; eventFlag <= 1'b1; state <= ST_HOLD;
              if (rwBit) status <= sampleBit ? CODE_RADDR_NACK : CODE_RADDR_ACK;
              else       status <= sampleBit ? CODE_WADDR_NACK : CODE_WADDR_ACK;
            end
          endcase
        end
        ST_RXBIT: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= 1'b0;
            2'd1: sclLow <= 1'b0;
            2'd2: sampleBit <= sdaIn;
            default: begin
              sclLow <= 1'b1;
              if (lastBit) state <= ST_RXACK;
            end
          endcase
        end
        ST_RXACK: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= ackEn;
            2'd1: sclLow <= 1'b0;
            2'd2: if (!ackEn && !sdaIn) begin
              sclLow <= 1'b0; sdaLow <= 1'b0; status <= CODE_LOST;
              eventFlag <= 1'b1; state <= ST_HOLD;
            end
            default: begin
              sclLow <= 1'b1; eventFlag <= 1'b1; state <= ST_HOLD;
              status <= ackEn ? CODE_RX_ACK : CODE_RX_NACK;
            end
          endcase
        end
        ST_STOP: if (tick) begin
          unique case (phase)
            2'd0: sdaLow <= 1'b1;
            2'd1: sclLow <= 1'b0;
            2'd2: sdaLow <= 1'b0;
            default: begin
              stopPending <= 1'b0; status <= CODE_NONE;
              state <= startReq ? ST_WAITFREE : ST_IDLE;
            end
          endcase
        end
        ST_HOLD: if (accept) begin
          eventFlag <= 1'b0;
          unique case (status)
            CODE_START, CODE_RSTART:      state <= ST_ADDR;
            CODE_RADDR_ACK, CODE_RX_ACK:  state <= ST_RXBIT;
            CODE_LOST: begin
              status <= CODE_NONE;
              state  <= ctrlStart ? ST_WAITFREE : ST_IDLE;
            end
            default: begin
              if (ctrlStop)       state <= ST_STOP;
              else if (ctrlStart) state <= ST_RSTART;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_master_rx_engine.sv
module i2c_master_rx_engine
  import i2c_mrx_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              ctrlWr,
  input  logic              ctrlStart,
  input  logic              ctrlStop,
  input  logic              ctrlAck,
  input  logic              ctrlClear,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [7:0]        status,
  output logic              eventFlag,
  output logic              stopPending
);

  dpStrobe_t  strobe;
  logic       tick, lastBit, txBit, rwBit, sampleBit;
  logic [1:0] phase;

  i2c_mrx_datapath #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleBit(sampleBit),
    .dataWr(dataWr), .dataIn(dataIn), .tick(tick), .phase(phase),
    .lastBit(lastBit), .txBit(txBit), .rwBit(rwBit), .dataOut(dataOut)
  );

  i2c_mrx_control u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .phase(phase), .lastBit(lastBit),
    .txBit(txBit), .rwBit(rwBit), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrlWr(ctrlWr), .ctrlStart(ctrlStart), .ctrlStop(ctrlStop),
    .ctrlAck(ctrlAck), .ctrlClear(ctrlClear), .strobe(strobe),
    .sampleBit(sampleBit), .sclOe(sclOe), .sdaOe(sdaOe), .status(status),
    .eventFlag(eventFlag), .stopPending(stopPending)
  );

endmodule

// File: rtl/i2c_mrx_checker.sv
module i2c_mrx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       ctrlWr,
  input logic       ctrlClear,
  input logic [7:0] status,
  input logic       eventFlag,
  input logic       stopPending
);

  // R11: status codes keep their low three bits at zero
  p_status_low_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    status[2:0] == 3'b000);

  // R2: SCL stays pulled low while an event is pending, unless arbitration was lost
  p_scl_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && status != 8'h38) |-> sclOe);

  // R8: after lost arbitration both lines are released
  p_lost_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && status == 8'h38) |-> (!sclOe && !sdaOe));

  // R11: a write with the clear bit drops the flag
  p_clear_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlClear && eventFlag) |=> !eventFlag);

  // R11: without a clearing write the flag stays set
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && !(ctrlWr && ctrlClear)) |=> eventFlag);

  // R6: with no event recorded the clock line is free
  p_idle_scl_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status == 8'hF8) |-> !sclOe);

  // R6: the stop bit self-clears only on completion of the STOP
  p_stop_selfclear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stopPending) && !$past(ctrlWr)) |-> status == 8'hF8);

endmodule

bind i2c_master_rx_engine i2c_mrx_checker u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .ctrlWr(ctrlWr),
  .ctrlClear(ctrlClear), .status(status), .eventFlag(eventFlag),
  .stopPending(stopPending)
);

// File: tb/i2c_master_rx_engine_test.sv
module i2c_master_rx_engine_test;

  localparam logic [6:0] SLV_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, ctrlStart = 0, ctrlStop = 0, ctrlAck = 0, ctrlClear = 0;
  logic dataWr = 0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut, status;
  logic sclOe, sdaOe, eventFlag, stopPending;
  logic slvDrive = 1'b0, forceSda = 1'b0;
  logic sclLine, sdaLine;

  int nChecks = 0, nErr = 0;
  logic [7:0] expCode[$];
  string      expTag[$];

  always #2 clk = ~clk;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slvDrive || forceSda);

  i2c_master_rx_engine uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .ctrlWr(ctrlWr), .ctrlStart(ctrlStart),
    .ctrlStop(ctrlStop), .ctrlAck(ctrlAck), .ctrlClear(ctrlClear),
    .dataWr(dataWr), .dataIn(dataIn), .dataOut(dataOut), .status(status),
    .eventFlag(eventFlag), .stopPending(stopPending)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  logic prevScl = 1'b1, prevSda = 1'b1, curScl, curSda;
  logic active = 0, isAddr = 0, reading = 0, matched = 0, mAck = 0;
  logic [7:0] rxSh = 0, txByte = 0, addrSeen = 0;
  int bitCnt = 0, idx = 0, stopCount = 0, ackCnt = 0;
  logic ackLog [2] = '{1'b0, 1'b0};

  function automatic logic [7:0] slvMem(input int i);
    return (i == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge clk) begin
    curScl = sclLine;
    curSda = sdaLine;
    if (prevScl && curScl && prevSda && !curSda) begin
      active = 1; isAddr = 1; reading = 0; bitCnt = 0; slvDrive = 0;
    end else if (prevScl && curScl && !prevSda && curSda) begin
      active = 0; slvDrive = 0; stopCount++;
    end else if (active && !prevScl && curScl) begin
      if (bitCnt < 8) rxSh = {rxSh[6:0], curSda};
      else if (reading && !isAddr) begin
        mAck = !curSda;
        if (ackCnt < 2) ackLog[ackCnt] = !curSda;
        ackCnt++;
      end
      bitCnt++;
    end else if (active && prevScl && !curScl) begin
      if (bitCnt == 8) begin
        if (isAddr) begin
          addrSeen = rxSh;
          matched  = (rxSh[7:1] == SLV_ADDR);
          slvDrive = matched;
          reading  = matched && rxSh[0];
        end else slvDrive = 0;
      end else if (bitCnt == 9) begin
        bitCnt = 0;
        if (isAddr) begin
          isAddr = 0; idx = 0;
          if (!matched) active = 0;
        end else if (!mAck) reading = 0;
        else idx++;
        if (reading && active) begin
          txByte = slvMem(idx); slvDrive = !txByte[7];
        end else slvDrive = 0;
      end else if (reading && !isAddr && bitCnt >= 1 && bitCnt <= 7)
        slvDrive = !txByte[7-bitCnt];
    end
    prevScl = curScl;
    prevSda = curSda;
  end

  // ---------------- scoreboard monitor ----------------
  logic flagSeen = 1'b0;
  always @(negedge clk) begin
    if (rstN && eventFlag && !flagSeen) begin
      if (expCode.size() == 0) check(1'b0, "R11 unexpected event", status, 8'hFF);
      else begin
        logic [7:0] c;
        string t;
        c = expCode.pop_front();
        t = expTag.pop_front();
        check(status == c, t, status, c);
      end
    end
    flagSeen = eventFlag;
  end

  // ---------------- driver tasks ----------------
  task automatic writeData(input logic [7:0] b);
    @(negedge clk); dataWr = 1; dataIn = b;
    @(negedge clk); dataWr = 0;
  endtask

  task automatic command(input logic st, input logic sp, input logic ak, input logic cl,
                         input logic hasExp, input logic [7:0] exp, input string tag);
    if (hasExp) begin expCode.push_back(exp); expTag.push_back(tag); end
    @(negedge clk);
    ctrlWr = 1; ctrlStart = st; ctrlStop = sp; ctrlAck = ak; ctrlClear = cl;
    @(negedge clk);
    ctrlWr = 0; ctrlStart = 0; ctrlStop = 0; ctrlAck = 0; ctrlClear = 0;
  endtask

  task automatic waitFlag(input string tag);
    int n = 0;
    while (!eventFlag && n < 6000) begin @(negedge clk); n++; end
    check(eventFlag, {tag, " event timeout"}, eventFlag, 1);
    @(negedge clk);
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (!(status == 8'hF8 && !stopPending) && n < 6000) begin @(negedge clk); n++; end
    check(status == 8'hF8, {tag, " idle status"}, status, 8'hF8);
  endtask

  task automatic finishRun();
    check(expCode.size() == 0, "R11 pending expectations", expCode.size(), 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(status == 8'hF8, "R1 status", status, 8'hF8);
    check(!eventFlag && !sclOe && !sdaOe, "R1 lines/flag", {eventFlag, sclOe, sdaOe}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R2 start, R3 read address, R4 two-byte read
    writeData({SLV_ADDR, 1'b1});
    command(1, 0, 0, 0, 1, 8'h08, "R2 start");
    waitFlag("R2");
    repeat (30) @(negedge clk);
    check(sclOe, "R2 SCL held low", sclOe, 1);
    command(0, 0, 0, 1, 1, 8'h40, "R3 read address ack");
    waitFlag("R3");
    check(addrSeen == {SLV_ADDR, 1'b1}, "R3 address MSB first", addrSeen, {SLV_ADDR, 1'b1});
    command(0, 0, 1, 1, 1, 8'h50, "R4 byte with ACK");
    waitFlag("R4");
    check(dataOut == 8'hA5, "R4 first byte", dataOut, 8'hA5);
    command(0, 0, 0, 1, 1, 8'h58, "R4 byte with NACK");
    waitFlag("R4");
    check(dataOut == 8'h3C, "R4 second byte", dataOut, 8'h3C);
    check(ackLog[0] == 1'b1 && ackLog[1] == 1'b0, "R4 ack slots", {ackLog[0], ackLog[1]}, 2'b10);

    // R5 repeated start to an absent slave
    command(1, 0, 0, 1, 1, 8'h10, "R5 repeated start");
    waitFlag("R5");
    writeData(8'h77);
    command(0, 0, 0, 1, 1, 8'h48, "R3 read address nack");
    waitFlag("R3");

    // R7 stop then start
    s0 = stopCount;
    command(1, 1, 0, 1, 1, 8'h08, "R7 stop+start");
    waitFlag("R7");
    check(stopCount == s0 + 1, "R7 stop seen", stopCount, s0 + 1);
    check(!stopPending, "R7 stop bit cleared", stopPending, 0);

    // R10 write addresses, R5 from transmitter code
    writeData({SLV_ADDR, 1'b0});
    command(0, 0, 0, 1, 1, 8'h18, "R10 write address ack");
    waitFlag("R10");
    command(1, 0, 0, 1, 1, 8'h10, "R5 repeated start after write");
    waitFlag("R5");
    writeData(8'h76);
    command(0, 0, 0, 1, 1, 8'h20, "R10 write address nack");
    waitFlag("R10");

    // R6 stop only
    s0 = stopCount;
    command(0, 1, 0, 1, 0, 8'h00, "");
    waitIdle("R6");
    repeat (5) @(negedge clk);
    check(!sclOe && !sdaOe && !eventFlag, "R6 bus released", {sclOe, sdaOe, eventFlag}, 0);
    check(!stopPending, "R6 stop bit self-clears", stopPending, 0);
    check(stopCount == s0 + 1, "R6 stop seen", stopCount, s0 + 1);

    // R8 arbitration loss during address, R11 clear=0 ignored, R9 start=0
    writeData({SLV_ADDR, 1'b1});
    command(1, 0, 0, 0, 1, 8'h08, "R2 start");
    waitFlag("R2");
    forceSda = 1;
    command(0, 0, 0, 1, 1, 8'h38, "R8 lost arbitration");
    waitFlag("R8");
    check(!sclOe && !sdaOe, "R8 lines released", {sclOe, sdaOe}, 0);
    forceSda = 0;
    command(0, 0, 1, 0, 0, 8'h00, "");
    repeat (20) @(negedge clk);
    check(eventFlag && status == 8'h38, "R11 write without clear ignored", status, 8'h38);
    command(0, 0, 0, 1, 0, 8'h00, "");
    repeat (100) @(negedge clk);
    check(status == 8'hF8 && !eventFlag, "R9 released after loss", status, 8'hF8);
    check(!sclOe && !sdaOe, "R9 no drive", {sclOe, sdaOe}, 0);

    // R8 again, then R9 start=1 waits for the free bus
    command(1, 0, 0, 0, 1, 8'h08, "R2 start");
    waitFlag("R2");
    forceSda = 1;
    command(0, 0, 0, 1, 1, 8'h38, "R8 lost arbitration");
    waitFlag("R8");
    command(1, 0, 0, 1, 1, 8'h08, "R9 start after free bus");
    repeat (300) @(negedge clk);
    check(!sclOe && !sdaOe && !eventFlag, "R9 waits while busy", {sclOe, sdaOe, eventFlag}, 0);
    forceSda = 0;
    waitFlag("R9");
    command(0, 0, 0, 1, 1, 8'h40, "R3 read address ack");
    waitFlag("R3");
    command(0, 0, 0, 1, 1, 8'h58, "R4 single byte NACK");
    waitFlag("R4");
    check(dataOut == 8'hA5, "R4 byte after restart", dataOut, 8'hA5);
    command(0, 1, 0, 1, 0, 8'h00, "");
    waitIdle("R6");
    finishRun();
  end

endmodule